// File: doc/BRIEF.md
# Sticky Prioritized Interrupt Identifier

This block gathers the interrupt requests of a CAN controller and presents exactly one pending source as a code in an 8-bit, read-only identification register. There are sixteen sources: a status-change source, which is gated by two enables, and one request flag for each of fifteen message slots. When the register is empty, the block loads the code of the highest-priority active source. The register then keeps that code until the named source goes inactive, even if higher-priority requests arrive while it waits. After that it loads the best source still pending, or returns to zero.

Software reads the code through a one-cycle registered read port. It clears the status-change source by strobing a status read, and it clears a message source with a write-one-to-clear pulse on that slot. A single interrupt line to the CPU is high whenever the code is non-zero. The code order is fixed by priority: status first, then the highest-numbered slot, then slots 1 upward.

Top module: `irq_src_latch`

## Requirements
- R1: After reset the interrupt line is low and a read of the register returns 00h.
- R2: The codes map to sources as follows: status change is 01h, slot 15 is 02h, and slot k for k = 1..14 is k+2 (03h..10h). Code 00h means nothing is pending. A request that is set at clock edge N can be visible in the code from edge N+1.
- R3: When the code is 00h and several sources are active, the code of the highest-priority source is loaded. Priority follows the code order, with 01h the highest and 10h the lowest.
- R4: A non-zero code does not change while its own source stays active, even if a higher-priority source becomes active.
- R5: When the latched source becomes inactive, the next edge loads the code of the highest-priority source still active, or 00h if none is active.
- R6: The interrupt output is high exactly when the latched code is non-zero.
- R7: The status-change source is active only while its pending flag is set and at least one of the error-interrupt enable and the status-interrupt enable is high.
- R8: A status event sets the status pending flag and a status read strobe clears it. A slot set pulse sets that slot's flag (bit k-1 of the slot buses is slot k) and a clear pulse on the same bit clears it. If a set and a clear reach the same flag in the same cycle, the set wins.
- R9: When read enable is high at an edge, the read data takes the code held just before that edge. Otherwise the read data keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_event_i | input | 1 | Pulse: status register changed |
| stat_rd_i | input | 1 | Pulse: status register read, clears the status pending flag |
| err_ie_i | input | 1 | Error-interrupt enable |
| stat_ie_i | input | 1 | Status-interrupt enable |
| slot_set_i | input | 15 | Per-slot request set pulses, bit k-1 is slot k |
| slot_clr_i | input | 15 | Per-slot write-one-to-clear pulses, bit k-1 is slot k |
| reg_re_i | input | 1 | Register read enable |
| reg_rdata_o | output | 8 | Registered read data (identification code) |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
On every cycle the assertions check that a live code stays stable, that the code stays within the legal range, that an empty register with an active status source loads 01h, that no active source leads to 00h, and that the read data agrees with the interrupt line. The exact code chosen among several competing slots, the order of handover as sources are cleared, the enable gating of the status source and the set-over-clear rule are shown only by the bench's directed scenarios and its random run against a reference model.

// File: rtl/irq_id_pkg.sv
package irq_id_pkg;
  localparam int CODE_W = 8;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t CODE_NONE = '0;
endpackage

// File: rtl/irq_req_gate.sv
// Holds the request flags and presents the sources as a vector in priority order.
// Bit 0 is status change, bit 1 is the top slot, and bits 2.. are slots 1 upward.
module irq_req_gate #(
  parameter int NUM_SLOTS = 15,
  localparam int NSRC = NUM_SLOTS + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stat_event_i,
  input  logic                 stat_rd_i,
  input  logic                 stat_en_i,
  input  logic [NUM_SLOTS-1:0] slot_set_i,
  input  logic [NUM_SLOTS-1:0] slot_clr_i,
  output logic [NSRC-1:0]      act_o
);
  logic                 stat_pend_q;
  logic [NUM_SLOTS-1:0] slot_q;

  // A set pulse overrides a clear that arrives in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_pend_q <= 1'b0;
      slot_q      <= '0;
    end else begin
      stat_pend_q <= stat_event_i | (stat_pend_q & ~stat_rd_i);
      slot_q      <= slot_set_i | (slot_q & ~slot_clr_i);
    end
  end

  assign act_o[0] = stat_pend_q & stat_en_i;
  assign act_o[1] = slot_q[NUM_SLOTS-1];

  for (genvar i = 0; i < NUM_SLOTS - 1; i++) begin : g_slot_order
    assign act_o[i+2] = slot_q[i];
  end
endmodule

// File: rtl/irq_prio_pick.sv
// Chooses the lowest-index active source and turns it into a code (index + 1).
module irq_prio_pick
  import irq_id_pkg::*;
#(
  parameter int NSRC = 16
) (
  input  logic [NSRC-1:0] req_i,
  output code_t           code_o
);
  function automatic code_t first_code(input logic [NSRC-1:0] v);
    code_t c = CODE_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) c = code_t'(i + 1);
    end
    return c;
  endfunction

  assign code_o = first_code(req_i);
endmodule

// File: rtl/irq_src_latch.sv
module irq_src_latch
  import irq_id_pkg::*;
#(
  parameter int NUM_SLOTS = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stat_event_i,
  input  logic                 stat_rd_i,
  input  logic                 err_ie_i,
  input  logic                 stat_ie_i,
  input  logic [NUM_SLOTS-1:0] slot_set_i,
  input  logic [NUM_SLOTS-1:0] slot_clr_i,
  input  logic                 reg_re_i,
  output logic [CODE_W-1:0]    reg_rdata_o,
  output logic                 irq_o
);
  localparam int NSRC = NUM_SLOTS + 1;

  logic [NSRC-1:0] act;
  code_t           sel_code;
  code_t           code_q;
  code_t           rdata_q;
  logic            cur_live;
  logic            reload;

  // Tells whether the source named by a code is still active.
  function automatic logic code_is_live(input logic [NSRC-1:0] v, input code_t c);
    logic hit = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (c == code_t'(i + 1) && v[i]) hit = 1'b1;
    end
    return hit;
  endfunction

  irq_req_gate #(.NUM_SLOTS(NUM_SLOTS)) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .stat_event_i (stat_event_i),
    .stat_rd_i    (stat_rd_i),
    .stat_en_i    (err_ie_i | stat_ie_i),
    .slot_set_i   (slot_set_i),
    .slot_clr_i   (slot_clr_i),
    .act_o        (act)
  );

  irq_prio_pick #(.NSRC(NSRC)) u_pick (
    .req_i  (act),
    .code_o (sel_code)
  );

  assign cur_live = code_is_live(act, code_q);
  assign reload   = ~cur_live;

  always_ff @(posedge clk) begin
    if (!rst_n)      code_q <= CODE_NONE;
    else if (reload) code_q <= sel_code;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        rdata_q <= CODE_NONE;
    else if (reg_re_i) rdata_q <= code_q;
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o       = (code_q != CODE_NONE);
endmodule

// File: rtl/irq_src_latch_chk.sv
module irq_src_latch_chk #(
  parameter int NUM_SLOTS = 15,
  localparam int NSRC = NUM_SLOTS + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] act,
  input logic [7:0]      code_q,
  input logic            cur_live,
  input logic            irq_o,
  input logic            reg_re_i,
  input logic [7:0]      reg_rdata_o
);
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != 8'd0 && cur_live) |=> $stable(code_q)); // R4

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    code_q <= 8'(NSRC)); // R2

  AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == 8'd0 && act[0]) |=> (code_q == 8'd1)); // R3

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (act == '0) |=> (code_q == 8'd0)); // R5

  AST_READ_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re_i |=> ((reg_rdata_o != 8'd0) == $past(irq_o))); // R6
endmodule

bind irq_src_latch irq_src_latch_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .act         (act),
  .code_q      (code_q),
  .cur_live    (cur_live),
  .irq_o       (irq_o),
  .reg_re_i    (reg_re_i),
  .reg_rdata_o (reg_rdata_o)
);

// File: tb/irq_src_latch_test.sv
module irq_src_latch_test;
  localparam int NS = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stat_event_i = 1'b0, stat_rd_i = 1'b0;
  logic          err_ie_i = 1'b1, stat_ie_i = 1'b1;
  logic [NS-1:0] slot_set_i = '0, slot_clr_i = '0;
  logic          reg_re_i = 1'b0;
  logic [7:0]    reg_rdata_o;
  logic          irq_o;

  int n_checks = 0, n_errs = 0;

  logic          m_pend = 1'b0;
  logic [NS-1:0] m_slot = '0;
  logic [7:0]    m_code = 8'd0, m_rdata = 8'd0;

  always #2 clk = ~clk;

  irq_src_latch #(.NUM_SLOTS(NS)) uut (.*);

  function automatic logic [7:0] model_pick(input logic st, input logic [NS-1:0] s);
    if (st) return 8'd1;
    if (s[NS-1]) return 8'd2;
    for (int k = 0; k < NS - 1; k++) if (s[k]) return 8'(k + 3);
    return 8'd0;
  endfunction

  function automatic logic model_live(input logic [7:0] c, input logic st, input logic [NS-1:0] s);
    if (c == 8'd1) return st;
    if (c == 8'd2) return s[NS-1];
    if (c >= 8'd3 && c <= 8'(NS + 1)) return s[c - 8'd3];
    return 1'b0;
  endfunction

  task automatic check(input logic ok, input string tag, input int act_v, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  // One clock: advance the model from pre-edge values, then compare at the falling edge.
  task automatic step();
    logic st_act;
    logic [7:0] n_code;
    @(posedge clk);
    st_act = m_pend & (err_ie_i | stat_ie_i);
    n_code = model_live(m_code, st_act, m_slot) ? m_code : model_pick(st_act, m_slot);
    if (reg_re_i) m_rdata = m_code;
    m_pend = stat_event_i | (m_pend & ~stat_rd_i);
    m_slot = slot_set_i | (m_slot & ~slot_clr_i);
    m_code = n_code;
    @(negedge clk);
    check(irq_o == (m_code != 0), "R6 irq line", int'(irq_o), int'(m_code != 0));
    check(reg_rdata_o == m_rdata, "R9 read data", int'(reg_rdata_o), int'(m_rdata));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic read_expect(input logic [7:0] exp_v, input string tag);
    reg_re_i = 1'b1;
    step();
    reg_re_i = 1'b0;
    check(reg_rdata_o == exp_v, tag, int'(reg_rdata_o), int'(exp_v));
  endtask

  task automatic set_slots(input logic [NS-1:0] m);
    slot_set_i = m; step(); slot_set_i = '0;
  endtask

  task automatic clr_slots(input logic [NS-1:0] m);
    slot_clr_i = m; step(); slot_clr_i = '0;
  endtask

  task automatic stat_pulse(input logic ev, input logic rd);
    stat_event_i = ev; stat_rd_i = rd; step(); stat_event_i = 1'b0; stat_rd_i = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_errs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(irq_o == 1'b0, "R1 irq after reset", int'(irq_o), 0);
    check(reg_rdata_o == 8'd0, "R1 data after reset", int'(reg_rdata_o), 0);
    read_expect(8'h00, "R1 read after reset");

    // R2: slot 14 is the lowest code, 10h
    set_slots(NS'(1) << 13); idle(1);
    read_expect(8'h10, "R2 slot14 code");
    clr_slots(NS'(1) << 13); idle(1);
    read_expect(8'h00, "R5 empty after clear");

    // R2: slot 15 is 02h
    set_slots(NS'(1) << 14); idle(1);
    read_expect(8'h02, "R2 slot15 code");
    clr_slots(NS'(1) << 14); idle(1);

    // R7: enables gate the status source
    err_ie_i = 1'b0; stat_ie_i = 1'b0;
    stat_pulse(1'b1, 1'b0); idle(2);
    check(irq_o == 1'b0, "R7 status masked", int'(irq_o), 0);
    read_expect(8'h00, "R7 status masked read");
    err_ie_i = 1'b1; idle(1);
    read_expect(8'h01, "R7 error enable alone");
    stat_pulse(1'b0, 1'b1); idle(1);
    read_expect(8'h00, "R8 status read clears");
    stat_ie_i = 1'b1;

    // R4: sticky code, then R5 handover in priority order
    set_slots(NS'(1) << 4); idle(1);
    read_expect(8'h07, "R2 slot5 code");
    stat_event_i = 1'b1; slot_set_i = NS'(1) << 14; step();
    stat_event_i = 1'b0; slot_set_i = '0; idle(3);
    read_expect(8'h07, "R4 held against higher");
    clr_slots(NS'(1) << 4); idle(1);
    read_expect(8'h01, "R5 next is status");
    stat_pulse(1'b0, 1'b1); idle(1);
    read_expect(8'h02, "R5 next is slot15");
    clr_slots(NS'(1) << 14); idle(1);
    read_expect(8'h00, "R5 none left");

    // R3: simultaneous arrivals
    stat_event_i = 1'b1; slot_set_i = '1; step();
    stat_event_i = 1'b0; slot_set_i = '0; idle(1);
    read_expect(8'h01, "R3 all at once");
    stat_rd_i = 1'b1; slot_clr_i = '1; step();
    stat_rd_i = 1'b0; slot_clr_i = '0; idle(2);
    read_expect(8'h00, "R5 all cleared");
    set_slots(NS'(5)); idle(1);
    read_expect(8'h03, "R3 slot1 over slot3");
    clr_slots(NS'(1)); idle(1);
    read_expect(8'h05, "R5 slot3 next");
    clr_slots(NS'(4)); idle(1);

    // R8: set wins over clear on the same flag
    slot_set_i = NS'(2); slot_clr_i = NS'(2); step();
    slot_set_i = '0; slot_clr_i = '0; idle(1);
    read_expect(8'h04, "R8 set beats clear");
    clr_slots(NS'(2)); idle(2);

    // Random traffic against the model (R3 R4 R5 R6 R9 per cycle)
    for (int i = 0; i < 4000; i++) begin
      stat_event_i = ($urandom % 16) == 0;
      stat_rd_i    = ($urandom % 8) == 0;
      err_ie_i     = ($urandom % 4) != 0;
      stat_ie_i    = ($urandom % 4) == 0;
      reg_re_i     = ($urandom % 3) == 0;
      for (int k = 0; k < NS; k++) begin
        slot_set_i[k] = ($urandom % 40) == 0;
        slot_clr_i[k] = ($urandom % 6) == 0;
      end
      step();
    end

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule